// File: doc/BRIEF.md
# Windowed Offset, Amplitude and Power Estimator

This block reduces a stream of decimated two's-complement samples to one statistic per window of N = 2^LOG2_N accepted samples. It serves as the response analyser of a single-tone self-test for a converter. A first window measures the DC offset as the mean of the raw samples. Software-free sequencing then latches that mean into a held offset register. Later windows subtract the held offset from every sample before they accumulate. Those windows produce either twice the mean magnitude, which is a multiplier-free estimate of the tone amplitude, or the mean square, which is the residual noise-plus-distortion power.

Samples arrive at a low rate, one every 128 clocks or so in the intended system. The single multiplication needed for the power result is therefore done by a shift-and-add squarer that takes SMP_W clocks per sample. A sample that arrives in power mode while a square is still in progress is dropped and flagged. Every division is a power-of-two shift, and results round toward minus infinity.

Top module: `tone_stat_engine`

## Requirements
- R1: `mode_i` selects the statistic: 0 = offset, 1 = amplitude, 2 = power. Each window closes after N accepted samples. `done_o` is then high for exactly one cycle, and `result_o` holds the new value from that cycle until the next window closes.
- R2: In offset mode, `result_o` equals floor(sum of raw samples / N), as a two's-complement value sign-extended to 2*SMP_W bits.
- R3: In amplitude mode, `result_o` equals floor(2 * sum of |sample - stored offset| / N).
- R4: In power mode, `result_o` equals floor(sum of (sample - stored offset)^2 / N). Each square is formed serially and occupies the squarer for SMP_W cycles.
- R5: A pulse on `load_ofs_i` copies the mean of the most recently completed offset window into the stored offset, which is visible on `offset_o`. Without that pulse the stored offset does not change, and completing an offset window alone does not alter it.
- R6: In power mode, a sample that arrives while the squarer is busy is dropped and is not counted. It sets `overrun_o`, which stays high until `clear_i` or reset.
- R7: `clear_i` discards the partial window, including a square in progress, and clears `overrun_o`. It leaves `result_o` and the stored offset unchanged.
- R8: In mode 3, samples are ignored: they are not counted, not accumulated and produce no `done_o`.
- R9: After reset, `result_o`, `offset_o`, `done_o` and `overrun_o` are all zero.
- R10: Full-scale inputs do not overflow. The sample value -2^(SMP_W-1) gives that mean. With that value stored as the offset, a constant 2^(SMP_W-1)-1 gives a power of (2^SMP_W-1)^2 and an amplitude of 2*(2^SMP_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Abandon the current window and clear overrun |
| mode_i | input | 2 | Statistic select (0 offset, 1 amplitude, 2 power, 3 idle) |
| load_ofs_i | input | 1 | Copy the last offset-window mean into the stored offset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Signed decimated sample |
| result_o | output | 2*SMP_W | Last window result |
| done_o | output | 1 | One-cycle window-complete pulse |
| offset_o | output | SMP_W | Stored offset |
| overrun_o | output | 1 | Sticky dropped-sample flag |

## Verification
The bench builds the block with SMP_W = 8 and LOG2_N = 3. With these values a window is only eight samples and a square takes eight clocks, so every mode, repeated offset reloads, clears in mid-window and mid-square, and back-to-back overruns fit in a short run. The narrow samples also make exact full-scale corners cheap to reach: offset -128, a difference of 255, and a power of 65025. The floor rounding of negative means is exercised as well.

// File: rtl/tse_pkg.sv
package tse_pkg;
  typedef enum logic [1:0] {
    MODE_OFS  = 2'd0,
    MODE_AMP  = 2'd1,
    MODE_PWR  = 2'd2,
    MODE_IDLE = 2'd3
  } tse_mode_e;
endpackage

// File: rtl/tse_ofs_path.sv
module tse_ofs_path #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SMP_W-1:0] mean_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] ofs_o,
  output logic [SMP_W-1:0] mag_o
);
  logic [SMP_W-1:0] ofs_q;
  logic signed [SMP_W:0] diff;
  logic signed [SMP_W:0] neg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_q <= '0;
    else if (load_i) ofs_q <= mean_i;
  end

  // |smp - ofs| is at most 2^SMP_W - 1, so it fits in SMP_W unsigned bits
  always_comb begin
    diff  = $signed({smp_i[SMP_W-1], smp_i}) - $signed({ofs_q[SMP_W-1], ofs_q});
    neg   = -diff;
    mag_o = diff[SMP_W] ? neg[SMP_W-1:0] : diff[SMP_W-1:0];
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/tse_serial_sq.sv
module tse_serial_sq #(
  parameter int OP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int CW = $clog2(OP_W + 1);

  logic [2*OP_W-1:0] mcand_q, prod_q;
  logic [OP_W-1:0]   mplr_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
      mplr_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        mcand_q <= {{OP_W{1'b0}}, op_i};
        mplr_q  <= op_i;
        prod_q  <= '0;
        cnt_q   <= CW'(OP_W);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (mplr_q[0]) prod_q <= prod_q + mcand_q;
        mcand_q <= mcand_q << 1;
        mplr_q  <= mplr_q >> 1;
        cnt_q   <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = prod_q;
endmodule

// File: rtl/tse_win_accum.sv
module tse_win_accum #(
  parameter int ACC_W  = 44,
  parameter int LOG2_N = 11,
  parameter int RES_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    add_i,
  input  logic                    half_i,
  input  logic signed [ACC_W-1:0] term_i,
  output logic                    done_o,
  output logic [RES_W-1:0]        result_o
);
  logic [LOG2_N-1:0]       cnt_q;
  logic signed [ACC_W-1:0] acc_q, sum, scaled;
  logic [RES_W-1:0]        res_q;
  logic                    done_q;

  always_comb begin
    sum    = acc_q + term_i;
    scaled = half_i ? (sum >>> (LOG2_N - 1)) : (sum >>> LOG2_N);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (add_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) begin
          res_q  <= scaled[RES_W-1:0];
          done_q <= 1'b1;
          acc_q  <= '0;
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/tone_stat_engine.sv
module tone_stat_engine #(
  parameter int SMP_W  = 16,
  parameter int LOG2_N = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [1:0]         mode_i,
  input  logic               load_ofs_i,
  input  logic               smp_valid_i,
  input  logic [SMP_W-1:0]   smp_i,
  output logic [2*SMP_W-1:0] result_o,
  output logic               done_o,
  output logic [SMP_W-1:0]   offset_o,
  output logic               overrun_o
);
  import tse_pkg::*;

  localparam int RES_W = 2 * SMP_W;
  localparam int ACC_W = 2 * SMP_W + LOG2_N + 1;

  tse_mode_e mode;
  assign mode = tse_mode_e'(mode_i);

  logic [SMP_W-1:0] mag, mean_q;
  logic [RES_W-1:0] prod, acc_res;
  logic             sq_busy, sq_done, sq_start;
  logic             acc_add, acc_done, ofs_win_q, ovr_q;
  logic signed [ACC_W-1:0] term;

  tse_ofs_path #(.SMP_W(SMP_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_ofs_i),
    .mean_i (mean_q),
    .smp_i  (smp_i),
    .ofs_o  (offset_o),
    .mag_o  (mag)
  );

  assign sq_start = smp_valid_i && (mode == MODE_PWR) && !clear_i;

  tse_serial_sq #(.OP_W(SMP_W)) u_sq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (clear_i),
    .start_i (sq_start),
    .op_i    (mag),
    .busy_o  (sq_busy),
    .done_o  (sq_done),
    .prod_o  (prod)
  );

  always_comb begin
    acc_add = 1'b0;
    term    = '0;
    unique case (mode)
      MODE_OFS: begin
        acc_add = smp_valid_i;
        term    = {{(ACC_W-SMP_W){smp_i[SMP_W-1]}}, smp_i};
      end
      MODE_AMP: begin
        acc_add = smp_valid_i;
        term    = {{(ACC_W-SMP_W){1'b0}}, mag};
      end
      MODE_PWR: begin
        acc_add = sq_done;
        term    = {{(ACC_W-RES_W){1'b0}}, prod};
      end
      default: begin
        acc_add = 1'b0;
        term    = '0;
      end
    endcase
  end

  tse_win_accum #(.ACC_W(ACC_W), .LOG2_N(LOG2_N), .RES_W(RES_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .add_i    (acc_add),
    .half_i   (mode == MODE_AMP),
    .term_i   (term),
    .done_o   (acc_done),
    .result_o (acc_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_win_q <= 1'b0;
      mean_q    <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (acc_add) ofs_win_q <= (mode == MODE_OFS);
      if (acc_done && ofs_win_q) mean_q <= acc_res[SMP_W-1:0];
      if (clear_i) ovr_q <= 1'b0;
      else if (smp_valid_i && (mode == MODE_PWR) && sq_busy) ovr_q <= 1'b1;
    end
  end

  assign result_o  = acc_res;
  assign done_o    = acc_done;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/tse_checker.sv
module tse_checker #(
  parameter int SMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             load_ofs_i,
  input logic [1:0]       mode_i,
  input logic             done_o,
  input logic             overrun_o,
  input logic [SMP_W-1:0] offset_o,
  input logic             sq_busy_i,
  input logic             sq_done_i
);
  logic [15:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_len <= '0;
    else if (sq_busy_i) busy_len <= busy_len + 1'b1;
    else                busy_len <= '0;
  end

  p_done_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_sq_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(busy_len) <= SMP_W);

  p_sq_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_done_i |-> !sq_busy_i);

  p_ofs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ofs_i |=> $stable(offset_o));

  p_overrun_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clear_i) |=> overrun_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!overrun_o && !done_o));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> !done_o);
endmodule

bind tone_stat_engine tse_checker #(.SMP_W(SMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .load_ofs_i (load_ofs_i),
  .mode_i     (mode_i),
  .done_o     (done_o),
  .overrun_o  (overrun_o),
  .offset_o   (offset_o),
  .sq_busy_i  (sq_busy),
  .sq_done_i  (sq_done)
);

// File: tb/tone_stat_engine_tb_top.sv
module tone_stat_engine_tb_top;
  localparam int W   = 8;
  localparam int L   = 3;
  localparam int N   = 1 << L;
  localparam int GAP = 12;
  localparam int WD  = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         load = 1'b0;
  logic         valid = 1'b0;
  logic [W-1:0] smp = '0;
  logic [2*W-1:0] result;
  logic         done;
  logic [W-1:0] offset;
  logic         overrun;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ofs_model = 0;
  int mean_model = 0;
  int arr[N];
  logic [2*W-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tone_stat_engine #(.SMP_W(W), .LOG2_N(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .mode_i(mode),
    .load_ofs_i(load), .smp_valid_i(valid), .smp_i(smp),
    .result_o(result), .done_o(done), .offset_o(offset), .overrun_o(overrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  // monitor: pops one expected item per window completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected done", longint'(result), 0);
      end else begin
        automatic logic [2*W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(result == e, t, longint'(result), longint'(e));
      end
    end
  end

  task automatic send(input int s, input int gap);
    @(negedge clk);
    smp = W'(s);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic fill_pat(input int seed);
    for (int i = 0; i < N; i++) arr[i] = ((i * 53 + seed * 29) % 256) - 128;
  endtask

  task automatic fill_const(input int v);
    for (int i = 0; i < N; i++) arr[i] = v;
  endtask

  function automatic int expect_val(input int m);
    int acc = 0;
    for (int i = 0; i < N; i++) begin
      int d = arr[i] - ofs_model;
      if (m == 0) acc += arr[i];
      else if (m == 1) acc += (d < 0) ? -d : d;
      else acc += d * d;
    end
    if (m == 1) return acc >>> (L - 1);
    return acc >>> L;
  endfunction

  // pushes expectation, then drives arr[first..N-1]
  task automatic run_window(input int m, input string tag, input int first);
    int e;
    e = expect_val(m);
    if (m == 0) mean_model = e;
    exp_q.push_back((2*W)'(e));
    tag_q.push_back(tag);
    @(negedge clk);
    mode = 2'(m);
    for (int i = first; i < N; i++) send(arr[i], GAP);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    ofs_model = mean_model;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(result == 0, "R9 result", longint'(result), 0);
    chk(done == 0, "R9 done", longint'(done), 0);
    chk(offset == 0, "R9 offset", longint'(offset), 0);
    chk(overrun == 0, "R9 overrun", longint'(overrun), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 offset window, R5 no automatic capture, then load
    fill_pat(1);
    run_window(0, "R2 offset mean", 0);
    chk(offset == 0, "R5 offset before load", longint'(offset), 0);
    pulse_load();
    chk($signed(offset) == mean_model, "R5 offset after load", longint'($signed(offset)), mean_model);

    // R3 amplitude and R4 power with offset removed
    fill_pat(2);
    run_window(1, "R3 amplitude", 0);
    fill_pat(3);
    run_window(2, "R4 power", 0);

    // second offset measurement with negative mean (floor)
    for (int i = 0; i < N; i++) arr[i] = -3 * i - 7;
    run_window(0, "R2 offset negative floor", 0);
    chk($signed(offset) == ofs_model, "R5 offset held across window", longint'($signed(offset)), ofs_model);
    pulse_load();
    chk($signed(offset) == mean_model, "R5 offset reload", longint'($signed(offset)), mean_model);
    fill_pat(5);
    run_window(2, "R4 power new offset", 0);
    fill_pat(6);
    run_window(1, "R3 amplitude new offset", 0);

    // R8 idle mode ignores samples
    held = result;
    @(negedge clk);
    mode = 2'd3;
    for (int i = 0; i < N + 2; i++) send(i * 11 - 40, 2);
    chk(result == held, "R8 idle result unchanged", longint'(result), longint'(held));
    fill_pat(7);
    run_window(1, "R8 window after idle samples", 0);

    // R7 clear mid-window (amplitude) and mid-square (power)
    held = result;
    @(negedge clk);
    mode = 2'd1;
    for (int i = 0; i < 3; i++) send(100 - i, GAP);
    pulse_clear();
    chk(result == held, "R7 result kept", longint'(result), longint'(held));
    chk($signed(offset) == ofs_model, "R7 offset kept", longint'($signed(offset)), ofs_model);
    fill_pat(8);
    run_window(1, "R7 amplitude after clear", 0);
    @(negedge clk);
    mode = 2'd2;
    send(90, 1);
    pulse_clear();
    repeat (GAP) @(negedge clk);
    fill_pat(9);
    run_window(2, "R7 power after aborted square", 0);

    // R6 overrun: second back-to-back sample dropped
    fill_pat(10);
    arr[0] = 50;
    exp_q.push_back((2*W)'(expect_val(2)));
    tag_q.push_back("R6 power with dropped sample");
    @(negedge clk);
    mode = 2'd2;
    smp = W'(arr[0]);
    valid = 1'b1;
    @(negedge clk);
    smp = W'(-100);
    @(negedge clk);
    valid = 1'b0;
    chk(overrun == 1'b1, "R6 overrun set", longint'(overrun), 1);
    repeat (GAP) @(negedge clk);
    for (int i = 1; i < N; i++) send(arr[i], GAP);
    repeat (4) @(negedge clk);
    chk(overrun == 1'b1, "R6 overrun sticky", longint'(overrun), 1);
    pulse_clear();
    chk(overrun == 1'b0, "R6 R7 overrun cleared", longint'(overrun), 0);

    // R10 full-scale corners
    fill_const(-128);
    run_window(0, "R10 offset min", 0);
    pulse_load();
    chk($signed(offset) == -128, "R10 offset loaded", longint'($signed(offset)), -128);
    fill_const(127);
    run_window(2, "R10 power full scale", 0);
    run_window(1, "R10 amplitude full scale", 0);
    run_window(0, "R10 offset max", 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all windows completed", longint'(exp_q.size()), 0);
    summary();
  end
endmodule